// File: doc/BRIEF.md
# Slave Address Response Controller

This block sits between the bit engine of a two-wire serial bus slave and its byte queues. Each time the bit engine has shifted in an address byte or a data byte, it raises a one-cycle strobe. On the next clock edge the controller registers its decision: whether the slave drives ACK or releases the line (NACK), and whether a received byte is written to the receive queue. In the same cycle it emits one-cycle event pulses: address match, general call match, do-not-respond error, receive overflow and transmit underflow.

The controller also latches the read/write bit of the last accepted address. When the receive queue still holds unread data and a master starts a write, it applies one of two selectable policies. Policy 1 refuses the address. Policy 0 accepts the address and then turns away every data byte. A slave transmit with the transmit side not ready is refused at the address. A non-matching address parks the controller until a STOP or the next address byte.

Top module: `slv_addr_resp`

## Requirements
- R1: An address byte whose bits 7:1 equal `ownAddr` is acknowledged and pulses `evAddrMatch`, unless a do-not-respond case below (R4, R6) applies.
- R2: The all-zero address is acknowledged and pulses `evGenCall` only while `genCallEn` is 1. With `genCallEn` at 0 it is NACKed, raises no event, and the data bytes after it get no decision.
- R3: Bit 0 of the address byte (1 = master reads) is captured in `rwLatched` on every own-address or general-call match. Any other address leaves it unchanged.
- R4: With `dnrMode` = 1, a matched write address that arrives while `rxNotEmpty` is 1 is NACKed and pulses `evDnr`.
- R5: With `dnrMode` = 0, a matched write address that arrives while `rxNotEmpty` is 1 is acknowledged and pulses `evDnr`. Every following data byte is NACKed and not stored.
- R6: A matched read address that arrives while `txReady` is 0 is NACKed and pulses `evDnr`.
- R7: After an accepted read address, a `masterAck` strobe that arrives while `txEmpty` is 1 pulses `evTxUnder`. With `txEmpty` at 0 it pulses nothing.
- R8: In an accepted write, a data byte that arrives while `rxFull` is 1 pulses `evRxOvf`, is NACKed and is not stored.
- R9: A non-matching address is NACKed. Data bytes after it get no decision until the next address byte, and `stopSeen` returns the controller to idle.
- R10: In an accepted write with room in the receive queue, each data byte is acknowledged and `storeByte` pulses.
- R11: Each decision (`decValid`, `ackOut`, `storeByte`) and each event appears exactly one clock after its input strobe and lasts one cycle.
- R12: After reset, all decision and event outputs and `rwLatched` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrValid | input | 1 | Address byte received strobe |
| addrByte | input | 8 | Address in bits 7:1, read/write in bit 0 |
| dataValid | input | 1 | Data byte received strobe (slave receive) |
| masterAck | input | 1 | Master acknowledged a transmitted byte |
| stopSeen | input | 1 | STOP detected on the bus |
| ownAddr | input | 7 | Own slave address |
| genCallEn | input | 1 | Accept the general call address |
| dnrMode | input | 1 | Do-not-respond policy select |
| rxNotEmpty | input | 1 | Receive queue holds data |
| rxFull | input | 1 | Receive queue full |
| txReady | input | 1 | Transmit side ready for a read |
| txEmpty | input | 1 | Transmit queue empty |
| decValid | output | 1 | ACK decision valid this cycle |
| ackOut | output | 1 | 1 = drive ACK, 0 = NACK |
| storeByte | output | 1 | Write received byte to the queue |
| rwLatched | output | 1 | Latched read/write bit |
| evAddrMatch | output | 1 | Own address match pulse |
| evGenCall | output | 1 | General call match pulse |
| evDnr | output | 1 | Do-not-respond error pulse |
| evRxOvf | output | 1 | Receive overflow pulse |
| evTxUnder | output | 1 | Transmit underflow pulse |

## Verification
The address decode is tried with the own address, the all-zero address with the enable off and on, and a foreign address. These patterns separate matching from general-call gating and show that a foreign address leaves the latched direction alone. Writes are run with an empty queue, a full queue and a non-empty queue under both policies. These tell normal storage apart from overflow loss and from the two refusal styles. Reads are run with the transmit side ready and not ready, and master acknowledges with the queue full and empty. These separate address-level refusal from underflow.

// File: rtl/slv_resp_pkg.sv
package slv_resp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_REJ, ST_TX, ST_IGNORE
  } respState_t;

  typedef struct packed {
    logic decide;
    logic ackBit;
    logic store;
    logic hitOwn;
    logic hitGc;
    logic dnrErr;
    logic rxOvf;
    logic txUnder;
    logic loadRw;
    logic rwVal;
  } respStrobe_t;
endpackage

// File: rtl/slv_resp_ctrl.sv
module slv_resp_ctrl
  import slv_resp_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic [ADDR_W:0]   addrByte,
  input  logic              dataValid,
  input  logic              masterAck,
  input  logic              stopSeen,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              genCallEn,
  input  logic              dnrMode,
  input  logic              rxNotEmpty,
  input  logic              rxFull,
  input  logic              txReady,
  input  logic              txEmpty,
  output respStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] GC_ADDR = '0;

  respState_t stateQ, stateD;
  logic [ADDR_W-1:0] addrField;
  logic rwBit, isOwn, isGc, isHit;

  assign addrField = addrByte[ADDR_W:1];
  assign rwBit     = addrByte[0];
  assign isOwn     = (addrField == ownAddr);
  assign isGc      = genCallEn && (addrField == GC_ADDR);
  assign isHit     = isOwn || isGc;

  always_comb begin
    strobe = '0;
    stateD = stateQ;
    if (addrValid) begin
      strobe.decide = 1'b1;
      if (!isHit) begin
        stateD = ST_IGNORE;
      end else begin
        strobe.hitOwn = isOwn;
        strobe.hitGc  = isGc;
        strobe.loadRw = 1'b1;
        strobe.rwVal  = rwBit;
        if (rwBit) begin
          if (txReady) begin
            strobe.ackBit = 1'b1;
            stateD = ST_TX;
          end else begin
            strobe.dnrErr = 1'b1;
            stateD = ST_IGNORE;
          end
        end else if (rxNotEmpty) begin
          strobe.dnrErr = 1'b1;
          if (dnrMode) begin
            stateD = ST_IGNORE;
          end else begin
            strobe.ackBit = 1'b1;
            stateD = ST_REJ;
          end
        end else begin
          strobe.ackBit = 1'b1;
          stateD = ST_RX;
        end
      end
    end else if (dataValid) begin
      if (stateQ == ST_RX) begin
        strobe.decide = 1'b1;
        if (rxFull) begin
          strobe.rxOvf = 1'b1;
        end else begin
          strobe.ackBit = 1'b1;
          strobe.store  = 1'b1;
        end
      end else if (stateQ == ST_REJ) begin
        strobe.decide = 1'b1;
      end
    end else if (masterAck && stateQ == ST_TX && txEmpty) begin
      strobe.txUnder = 1'b1;
    end
    if (stopSeen && !addrValid) stateD = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  AST_IGNORE_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_IGNORE && !addrValid) |-> (!strobe.store && !strobe.ackBit && !strobe.decide)); // R9
  AST_REJ_NO_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_REJ && !addrValid) |-> !strobe.store); // R5
endmodule

// File: rtl/slv_resp_dp.sv
module slv_resp_dp
  import slv_resp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  respStrobe_t strobe,
  output logic        decValid,
  output logic        ackOut,
  output logic        storeByte,
  output logic        rwLatched,
  output logic        evAddrMatch,
  output logic        evGenCall,
  output logic        evDnr,
  output logic        evRxOvf,
  output logic        evTxUnder
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      decValid    <= 1'b0;
      ackOut      <= 1'b0;
      storeByte   <= 1'b0;
      rwLatched   <= 1'b0;
      evAddrMatch <= 1'b0;
      evGenCall   <= 1'b0;
      evDnr       <= 1'b0;
      evRxOvf     <= 1'b0;
      evTxUnder   <= 1'b0;
    end else begin
      decValid    <= strobe.decide;
      ackOut      <= strobe.decide && strobe.ackBit;
      storeByte   <= strobe.store;
      evAddrMatch <= strobe.hitOwn;
      evGenCall   <= strobe.hitGc;
      evDnr       <= strobe.dnrErr;
      evRxOvf     <= strobe.rxOvf;
      evTxUnder   <= strobe.txUnder;
      if (strobe.loadRw) rwLatched <= strobe.rwVal;
    end
  end

  AST_OVF_NO_STORE: assert property (@(posedge clk) disable iff (!rstN)
    evRxOvf |-> (decValid && !ackOut && !storeByte)); // R8
  AST_STORE_ACKED: assert property (@(posedge clk) disable iff (!rstN)
    storeByte |-> (decValid && ackOut)); // R10
  AST_EVENT_WITH_DECISION: assert property (@(posedge clk) disable iff (!rstN)
    (evAddrMatch || evGenCall) |-> decValid); // R1
  AST_RW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(evAddrMatch || evGenCall) |-> $stable(rwLatched)); // R3
endmodule

// File: rtl/slv_addr_resp.sv
module slv_addr_resp
  import slv_resp_pkg::*;
#(
  parameter int ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic [ADDR_W:0]   addrByte,
  input  logic              dataValid,
  input  logic              masterAck,
  input  logic              stopSeen,
  input  logic [ADDR_W-1:0] ownAddr,
  input  logic              genCallEn,
  input  logic              dnrMode,
  input  logic              rxNotEmpty,
  input  logic              rxFull,
  input  logic              txReady,
  input  logic              txEmpty,
  output logic              decValid,
  output logic              ackOut,
  output logic              storeByte,
  output logic              rwLatched,
  output logic              evAddrMatch,
  output logic              evGenCall,
  output logic              evDnr,
  output logic              evRxOvf,
  output logic              evTxUnder
);
  respStrobe_t strobe;

  slv_resp_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .addrByte(addrByte),
    .dataValid(dataValid), .masterAck(masterAck), .stopSeen(stopSeen),
    .ownAddr(ownAddr), .genCallEn(genCallEn), .dnrMode(dnrMode),
    .rxNotEmpty(rxNotEmpty), .rxFull(rxFull), .txReady(txReady),
    .txEmpty(txEmpty), .strobe(strobe)
  );

  slv_resp_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .decValid(decValid),
    .ackOut(ackOut), .storeByte(storeByte), .rwLatched(rwLatched),
    .evAddrMatch(evAddrMatch), .evGenCall(evGenCall), .evDnr(evDnr),
    .evRxOvf(evRxOvf), .evTxUnder(evTxUnder)
  );
endmodule

// File: tb/slv_addr_resp_bench.sv
module slv_addr_resp_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic addrValid = 0, dataValid = 0, masterAck = 0, stopSeen = 0;
  logic [7:0] addrByte = '0;
  logic [6:0] ownAddr = 7'h2A;
  logic genCallEn = 0, dnrMode = 0, rxNotEmpty = 0, rxFull = 0, txReady = 1, txEmpty = 0;
  logic decValid, ackOut, storeByte, rwLatched, evAddrMatch, evGenCall, evDnr, evRxOvf, evTxUnder;

  int checks = 0, errors = 0;
  // reference model state: 0 idle, 1 rx, 2 reject, 3 tx, 4 ignore
  int mState = 0;
  bit eDec, eAck, eSto, eRw, eMat, eGc, eDnr, eOvf, eUnd;

  always #10 clk = ~clk;

  slv_addr_resp u_slv_addr_resp (
    .clk(clk), .rstN(rstN), .addrValid(addrValid), .addrByte(addrByte),
    .dataValid(dataValid), .masterAck(masterAck), .stopSeen(stopSeen),
    .ownAddr(ownAddr), .genCallEn(genCallEn), .dnrMode(dnrMode),
    .rxNotEmpty(rxNotEmpty), .rxFull(rxFull), .txReady(txReady), .txEmpty(txEmpty),
    .decValid(decValid), .ackOut(ackOut), .storeByte(storeByte), .rwLatched(rwLatched),
    .evAddrMatch(evAddrMatch), .evGenCall(evGenCall), .evDnr(evDnr),
    .evRxOvf(evRxOvf), .evTxUnder(evTxUnder)
  );

  always @(posedge clk) begin
    {eDec, eAck, eSto, eMat, eGc, eDnr, eOvf, eUnd} = '0;
    if (!rstN) begin
      mState = 0; eRw = 0;
    end else begin
      if (addrValid) begin
        bit own, gc;
        own = (addrByte[7:1] == ownAddr);
        gc = genCallEn && (addrByte[7:1] == 0);
        eDec = 1;
        if (!(own || gc)) mState = 4;
        else begin
          eMat = own; eGc = gc; eRw = addrByte[0];
          if (addrByte[0]) begin
            if (txReady) begin eAck = 1; mState = 3; end
            else begin eDnr = 1; mState = 4; end
          end else if (rxNotEmpty) begin
            eDnr = 1;
            if (dnrMode) mState = 4; else begin eAck = 1; mState = 2; end
          end else begin eAck = 1; mState = 1; end
        end
      end else if (dataValid) begin
        if (mState == 1) begin
          eDec = 1;
          if (rxFull) eOvf = 1; else begin eAck = 1; eSto = 1; end
        end else if (mState == 2) eDec = 1;
      end else if (masterAck && mState == 3 && txEmpty) eUnd = 1;
      if (stopSeen && !addrValid) mState = 0;
    end
  end

  task automatic cmp(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  // continuous comparison against the model on every clock
  always @(negedge clk) if (rstN) begin
    cmp("R11 decValid", decValid, eDec);
    cmp("R11 ackOut", ackOut, eAck);
    cmp("R10 storeByte", storeByte, eSto);
    cmp("R3 rwLatched", rwLatched, eRw);
    cmp("R1 evAddrMatch", evAddrMatch, eMat);
    cmp("R2 evGenCall", evGenCall, eGc);
    cmp("R6 evDnr", evDnr, eDnr);
    cmp("R8 evRxOvf", evRxOvf, eOvf);
    cmp("R7 evTxUnder", evTxUnder, eUnd);
  end

  task automatic sendAddr(input logic [6:0] a, input logic rw);
    @(negedge clk); addrByte = {a, rw}; addrValid = 1;
    @(negedge clk); addrValid = 0;
  endtask
  task automatic sendData();
    @(negedge clk); dataValid = 1;
    @(negedge clk); dataValid = 0;
  endtask
  task automatic sendMack();
    @(negedge clk); masterAck = 1;
    @(negedge clk); masterAck = 0;
  endtask
  task automatic sendStop();
    @(negedge clk); stopSeen = 1;
    @(negedge clk); stopSeen = 0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    cmp("R12 decValid", decValid, 0); cmp("R12 ackOut", ackOut, 0);
    cmp("R12 rwLatched", rwLatched, 0); cmp("R12 evDnr", evDnr, 0);
    rstN = 1;
    // R1, R10, R8 normal write
    sendAddr(7'h2A, 0);
    cmp("R1 ack own", ackOut, 1); cmp("R1 match", evAddrMatch, 1);
    @(negedge clk); cmp("R11 pulse ends", evAddrMatch, 0);
    sendData(); cmp("R10 ack", ackOut, 1); cmp("R10 store", storeByte, 1);
    rxFull = 1; sendData(); cmp("R8 ovf", evRxOvf, 1); cmp("R8 no store", storeByte, 0);
    rxFull = 0; sendStop();
    // R2 general call disabled then enabled
    sendAddr(7'h00, 0); cmp("R2 gc off nack", ackOut, 0); cmp("R2 gc off event", evGenCall, 0);
    sendData(); cmp("R2 no decision", decValid, 0);
    genCallEn = 1;
    sendAddr(7'h00, 0); cmp("R2 gc ack", ackOut, 1); cmp("R2 gc event", evGenCall, 1);
    cmp("R3 rw write", rwLatched, 0);
    sendStop();
    // R9, R3 foreign read address
    sendAddr(7'h11, 1); cmp("R9 nack", ackOut, 0); cmp("R3 unchanged", rwLatched, 0);
    sendData(); cmp("R9 data ignored", decValid, 0);
    sendStop();
    // R7 read with underflow
    sendAddr(7'h2A, 1); cmp("R3 rw read", rwLatched, 1); cmp("R1 read ack", ackOut, 1);
    sendMack(); cmp("R7 no under", evTxUnder, 0);
    txEmpty = 1; sendMack(); cmp("R7 under", evTxUnder, 1);
    txEmpty = 0; sendStop();
    // R6 read not ready
    txReady = 0; sendAddr(7'h2A, 1); cmp("R6 nack", ackOut, 0); cmp("R6 dnr", evDnr, 1);
    txReady = 1; sendStop();
    // R4 policy 1
    rxNotEmpty = 1; dnrMode = 1;
    sendAddr(7'h2A, 0); cmp("R4 nack", ackOut, 0); cmp("R4 dnr", evDnr, 1);
    sendData(); cmp("R4 no decision", decValid, 0);
    sendStop();
    // R5 policy 0
    dnrMode = 0;
    sendAddr(7'h2A, 0); cmp("R5 ack", ackOut, 1); cmp("R5 dnr", evDnr, 1);
    sendData(); cmp("R5 data nack", ackOut, 0); cmp("R5 decided", decValid, 1);
    cmp("R5 no store", storeByte, 0);
    sendData(); cmp("R5 second nack", ackOut, 0);
    sendStop(); rxNotEmpty = 0;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule